// File: doc/BRIEF.md
# Byte Datapath: Logic/Arithmetic, Extract and Shift-Add Unit

This block is the purely combinational 8-bit execution path for a small controller's two byte registers, called A and B here. In one evaluation it takes the current A and B, an operation kind, a function code and the immediate fields of the instruction. It returns the values A and B should take next and a flag that says whether the byte written to the destination is zero. Register storage and the wider pointer arithmetic sit outside this block. The caller latches `a_o`, `b_o` and `zero_o` on its own clock.

Four kinds of work are supported. The first is a sixteen-function register-to-register set that always writes A. The second is a reduced four-function set that combines one register with a 7-bit immediate. The third is a field extract that shifts B by one to eight places and places the bits that fall out in A, aligned to the least significant bit. The fourth is a shift-then-add of one register by a 3-bit shift count and a 4-bit addend. All arithmetic wraps modulo 256, and every shift fills the vacated bit positions with zeros.

Top module: `alu8_datapath`

## Requirements
- R1: With `kind_i`=00, `a_o` is f(A,B) for `code_i` 0..7 in this order: A; A+B; A−B; A+(A&B); A−1; ~(A^B); 0x00; 0xFF. Results wrap modulo 256 and `b_o` equals `b_i`.
- R2: With `kind_i`=00, `a_o` is f(A,B) for `code_i` 8..15 in this order: ~A; ~(A|B); ~(A&B); ~B; A^B; B; A&B; A|B. `b_o` equals `b_i`.
- R3: With `kind_i`=01, the destination becomes dest op `imm_i`. The 7-bit immediate is zero-extended, and `code_i[1:0]` selects the operation: 00 add, 01 subtract (dest−imm), 10 AND, 11 OR. The result wraps modulo 256, and `code_i[3:2]` has no effect.
- R4: For `kind_i` 01 and 11, `dst_b_i`=0 makes A the operand and destination, and `dst_b_i`=1 makes B the operand and destination. The other register passes through unchanged.
- R5: With `kind_i`=10 and `dir_left_i`=0, n=`shamt_i`+1. `b_o` = B>>n, and `a_o` holds the n least significant bits of B in bits [n−1:0].
- R6: With `kind_i`=10 and `dir_left_i`=1, n=`shamt_i`+1. `b_o` = (B<<n) mod 256, and `a_o` holds the n most significant bits of B in bits [n−1:0], keeping their order.
- R7: On extract, the bits of `a_o` above the extracted field are zero. `shamt_i`=7 moves the whole of B into A and leaves `b_o`=0 in either direction.
- R8: With `kind_i`=11, the destination becomes ((dest shifted by `shamt_i`) + `addend_i`) mod 256. The shift is left when `dir_left_i`=1 and right when it is 0, with zero fill. A shift count of 0 leaves the value unshifted.
- R9: `zero_o` is 1 exactly when the byte written to the destination is 0. For `kind_i` 00 and 10 that byte is the new A. For 01 and 11 it is the register chosen by `dst_b_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind_i | input | 2 | Operation kind: 00 register function, 01 immediate op, 10 extract, 11 shift-add |
| code_i | input | 4 | Function code; only bits [1:0] used by kind 01 |
| dst_b_i | input | 1 | Destination/operand select for kinds 01 and 11 (0 = A, 1 = B) |
| dir_left_i | input | 1 | Shift direction for kinds 10 and 11 (0 = right, 1 = left) |
| imm_i | input | 7 | Immediate for kind 01 |
| shamt_i | input | 3 | Extract count minus one (kind 10) or shift count (kind 11) |
| addend_i | input | 4 | Addend for kind 11 |
| a_i | input | 8 | Current A |
| b_i | input | 8 | Current B |
| a_o | output | 8 | Next A |
| b_o | output | 8 | Next B |
| zero_o | output | 1 | Destination result is zero |

## Verification
The bench goes after the extract extremes. A count of one tests an off-by-one in n=i+1, which would move either no bits or two. A count of eight tests a shift that is truncated or drops the whole byte, which would leave stale bits in B or an empty A. Left extracts check bit order, which a design that reversed or mis-aligned the field would get wrong. Borrow and carry wrap (A−B with B>A, add overflow, decrement of zero) would show up as a wrong byte or a wrong zero flag. Destination selection and the unused upper code bits of the immediate form are checked at the ports, so a design that wrote the wrong register or decoded the wrong code bits gives visibly wrong outputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [1:0] {
    KIND_REG   = 2'b00,
    KIND_IMM   = 2'b01,
    KIND_EXTR  = 2'b10,
    KIND_SHADD = 2'b11
  } alu8_kind_e;

  typedef enum logic [1:0] {
    IOP_ADD = 2'b00,
    IOP_SUB = 2'b01,
    IOP_AND = 2'b10,
    IOP_OR  = 2'b11
  } alu8_iop_e;
endpackage

// File: rtl/alu8_fn16.sv
module alu8_fn16 #(
  parameter int DW = 8
) (
  input  logic [3:0]    code_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  function automatic logic [DW-1:0] fn16(input logic [3:0] c,
                                         input logic [DW-1:0] a,
                                         input logic [DW-1:0] b);
    case (c)
      4'd0:    fn16 = a;
      4'd1:    fn16 = a + b;
      4'd2:    fn16 = a - b;
      4'd3:    fn16 = a + (a & b);
      4'd4:    fn16 = a - ONE;
      4'd5:    fn16 = ~(a ^ b);
      4'd6:    fn16 = '0;
      4'd7:    fn16 = '1;
      4'd8:    fn16 = ~a;
      4'd9:    fn16 = ~(a | b);
      4'd10:   fn16 = ~(a & b);
      4'd11:   fn16 = ~b;
      4'd12:   fn16 = a ^ b;
      4'd13:   fn16 = b;
      4'd14:   fn16 = a & b;
      default: fn16 = a | b;
    endcase
  endfunction

  assign res_o = fn16(code_i, a_i, b_i);
endmodule

// File: rtl/alu8_immop.sv
module alu8_immop
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IMM_W = 7
) (
  input  logic [1:0]       op_i,
  input  logic [DW-1:0]    s_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [DW-1:0]    res_o
);
  function automatic logic [DW-1:0] immop(input logic [1:0] op,
                                          input logic [DW-1:0] s,
                                          input logic [DW-1:0] k);
    case (alu8_iop_e'(op))
      IOP_ADD: immop = s + k;
      IOP_SUB: immop = s - k;
      IOP_AND: immop = s & k;
      default: immop = s | k;
    endcase
  endfunction

  assign res_o = immop(op_i, s_i, DW'(imm_i));
endmodule

// File: rtl/alu8_extract.sv
module alu8_extract #(
  parameter int DW   = 8,
  parameter int SH_W = 3
) (
  input  logic [DW-1:0] b_i,
  input  logic [SH_W-1:0] idx_i,
  input  logic          dir_left_i,
  output logic [DW-1:0] field_o,
  output logic [DW-1:0] rest_o,
  output logic [SH_W:0] count_o
);
  localparam int XW = 2 * DW;

  logic [XW-1:0] wide_l;
  logic [XW-1:0] wide_r;

  assign count_o = {1'b0, idx_i} + (SH_W+1)'(1);
  assign wide_l  = {{DW{1'b0}}, b_i} << count_o;
  assign wide_r  = {b_i, {DW{1'b0}}} >> count_o;

  always_comb begin
    if (dir_left_i) begin
      field_o = wide_l[XW-1:DW];
      rest_o  = wide_l[DW-1:0];
    end else begin
      field_o = wide_r[DW-1:0] >> (DW - int'(count_o));
      rest_o  = wide_r[XW-1:DW];
    end
  end
endmodule

// File: rtl/alu8_shadd.sv
module alu8_shadd #(
  parameter int DW    = 8,
  parameter int SH_W  = 3,
  parameter int ADD_W = 4
) (
  input  logic [DW-1:0]    s_i,
  input  logic             dir_left_i,
  input  logic [SH_W-1:0]  amt_i,
  input  logic [ADD_W-1:0] add_i,
  output logic [DW-1:0]    res_o
);
  function automatic logic [DW-1:0] shadd(input logic [DW-1:0] s,
                                          input logic left,
                                          input logic [SH_W-1:0] amt,
                                          input logic [ADD_W-1:0] k);
    logic [DW-1:0] sh;
    sh = left ? (s << amt) : (s >> amt);
    shadd = sh + DW'(k);
  endfunction

  assign res_o = shadd(s_i, dir_left_i, amt_i, add_i);
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IMM_W = 7,
  parameter int SH_W  = 3,
  parameter int ADD_W = 4
) (
  input  logic [1:0]       kind_i,
  input  logic [3:0]       code_i,
  input  logic             dst_b_i,
  input  logic             dir_left_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [ADD_W-1:0] addend_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic [DW-1:0]    a_o,
  output logic [DW-1:0]    b_o,
  output logic             zero_o
);
  // Named internal events, observed by the bound checker.
  logic [DW-1:0] src_val;
  logic [DW-1:0] fn_res;
  logic [DW-1:0] imm_res;
  logic [DW-1:0] sha_res;
  logic [DW-1:0] ext_field;
  logic [DW-1:0] ext_rest;
  logic [SH_W:0] ext_count;
  logic [DW-1:0] dst_res;

  assign src_val = dst_b_i ? b_i : a_i;

  alu8_fn16 #(.DW(DW)) u_fn16 (
    .code_i (code_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (fn_res)
  );

  alu8_immop #(.DW(DW), .IMM_W(IMM_W)) u_immop (
    .op_i  (code_i[1:0]),
    .s_i   (src_val),
    .imm_i (imm_i),
    .res_o (imm_res)
  );

  alu8_extract #(.DW(DW), .SH_W(SH_W)) u_extract (
    .b_i        (b_i),
    .idx_i      (shamt_i),
    .dir_left_i (dir_left_i),
    .field_o    (ext_field),
    .rest_o     (ext_rest),
    .count_o    (ext_count)
  );

  alu8_shadd #(.DW(DW), .SH_W(SH_W), .ADD_W(ADD_W)) u_shadd (
    .s_i        (src_val),
    .dir_left_i (dir_left_i),
    .amt_i      (shamt_i),
    .add_i      (addend_i),
    .res_o      (sha_res)
  );

  always_comb begin
    a_o     = a_i;
    b_o     = b_i;
    dst_res = a_i;
    case (alu8_kind_e'(kind_i))
      KIND_REG: begin
        a_o     = fn_res;
        dst_res = fn_res;
      end
      KIND_IMM: begin
        dst_res = imm_res;
        if (dst_b_i) b_o = imm_res;
        else         a_o = imm_res;
      end
      KIND_EXTR: begin
        a_o     = ext_field;
        b_o     = ext_rest;
        dst_res = ext_field;
      end
      default: begin
        dst_res = sha_res;
        if (dst_b_i) b_o = sha_res;
        else         a_o = sha_res;
      end
    endcase
  end

  assign zero_o = (dst_res == '0);
endmodule

// File: rtl/alu8_datapath_chk.sv
module alu8_datapath_chk #(
  parameter int DW   = 8,
  parameter int SH_W = 3
) (
  input logic [1:0]    kind_i,
  input logic          dst_b_i,
  input logic          dir_left_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [DW-1:0] a_o,
  input logic [DW-1:0] b_o,
  input logic          zero_o,
  input logic [SH_W:0] ext_count
);
  always_comb begin
    if (!$isunknown({kind_i, dst_b_i, dir_left_i, a_i, b_i})) begin
      // R1 / R2: the register-function kind never disturbs B
      if (kind_i == 2'b00)
        assert_reg_keeps_b_R1: assert (b_o == b_i);
      // R4: the register not selected passes through
      if (kind_i == 2'b01 || kind_i == 2'b11) begin
        if (dst_b_i) assert_other_kept_R4: assert (a_o == a_i);
        else         assert_other_kept_b_R4: assert (b_o == b_i);
      end
      // R5: a right extract loses no bit of B
      if (kind_i == 2'b10 && !dir_left_i)
        assert_extract_right_conserves_R5:
          assert (DW'((b_o << ext_count) | a_o) == b_i);
      // R6: a left extract loses no bit of B
      if (kind_i == 2'b10 && dir_left_i)
        assert_extract_left_conserves_R6:
          assert (DW'((a_o << (DW - int'(ext_count))) | (b_o >> ext_count)) == b_i);
      // R7: nothing above the extracted field
      if (kind_i == 2'b10)
        assert_field_clean_R7: assert ((a_o >> ext_count) == '0);
      // R9: flag tracks the written byte
      if (kind_i[0] && dst_b_i)
        assert_zero_flag_b_R9: assert (zero_o == (b_o == '0));
      else
        assert_zero_flag_a_R9: assert (zero_o == (a_o == '0));
    end
  end
endmodule

bind alu8_datapath alu8_datapath_chk #(.DW(DW), .SH_W(SH_W)) u_chk (
  .kind_i     (kind_i),
  .dst_b_i    (dst_b_i),
  .dir_left_i (dir_left_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .a_o        (a_o),
  .b_o        (b_o),
  .zero_o     (zero_o),
  .ext_count  (ext_count)
);

// File: tb/tb_alu8_datapath.sv
module tb_alu8_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] kind;
  logic [3:0] code;
  logic       dstb, dirl;
  logic [6:0] imm;
  logic [2:0] sh;
  logic [3:0] addn;
  logic [7:0] a, b;
  logic [7:0] a_o, b_o;
  logic       zero_o;

  int checks = 0;
  int fails  = 0;
  bit timed_out = 0;

  alu8_datapath dut (
    .kind_i(kind), .code_i(code), .dst_b_i(dstb), .dir_left_i(dirl),
    .imm_i(imm), .shamt_i(sh), .addend_i(addn), .a_i(a), .b_i(b),
    .a_o(a_o), .b_o(b_o), .zero_o(zero_o)
  );

  int pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h7E};

  task automatic apply(input int k, input int c, input int d, input int l,
                       input int im, input int s, input int ad,
                       input int av, input int bv);
    @(posedge clk);
    kind = k[1:0]; code = c[3:0]; dstb = d[0]; dirl = l[0];
    imm = im[6:0]; sh = s[2:0]; addn = ad[3:0]; a = av[7:0]; b = bv[7:0];
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int ea, input int eb, input int ez);
    checks++;
    if (a_o !== ea[7:0] || b_o !== eb[7:0] || zero_o !== ez[0]) begin
      fails++;
      $display("FAIL %s: got a=%02h b=%02h z=%0d expected a=%02h b=%02h z=%0d",
               req, a_o, b_o, zero_o, ea[7:0], eb[7:0], ez[0]);
    end
  endtask

  function automatic int ref16(int c, int x, int y);
    case (c)
      0: return x;
      1: return (x + y) % 256;
      2: return (x - y + 256) % 256;
      3: return (x + (x & y)) % 256;
      4: return (x + 255) % 256;
      5: return 255 - (x ^ y);
      6: return 0;
      7: return 255;
      8: return 255 - x;
      9: return 255 - (x | y);
      10: return 255 - (x & y);
      11: return 255 - y;
      12: return x ^ y;
      13: return y;
      14: return x & y;
      default: return x | y;
    endcase
  endfunction

  function automatic int refimm(int op, int s, int k);
    case (op % 4)
      0: return (s + k) % 256;
      1: return (s - k + 256) % 256;
      2: return s & k;
      default: return s | k;
    endcase
  endfunction

  function automatic int pow2(int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * 2;
    return r;
  endfunction

  // Extract field built bit by bit.
  function automatic int ref_field(int left, int n, int bv);
    int f = 0;
    for (int k = 0; k < n; k++) begin
      int src = left ? (8 - n + k) : k;
      if ((bv / pow2(src)) % 2 == 1) f = f + pow2(k);
    end
    return f;
  endfunction

  function automatic int ref_rest(int left, int n, int bv);
    if (left) return (bv * pow2(n)) % 256;
    return bv / pow2(n);
  endfunction

  function automatic int ref_shadd(int left, int s, int i, int j);
    int v = left ? (s * pow2(i)) % 256 : s / pow2(i);
    return (v + j) % 256;
  endfunction

  task automatic t_idle;
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 idle zero", 0, 0, 1);
  endtask

  task automatic t_fn_low;
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 6; p++) begin
        int x = pats[p];
        int y = pats[(p + 2) % 6];
        int r = ref16(c, x, y);
        apply(0, c, 1, 1, 7'h55, 5, 9, x, y);
        chk("R1 fn low", r, y, r == 0);
      end
    apply(0, 4, 0, 0, 0, 0, 0, 0, 8'h12);
    chk("R1 decrement wraps", 8'hFF, 8'h12, 0);
    apply(0, 2, 0, 0, 0, 0, 0, 8'h10, 8'h20);
    chk("R1 sub borrow", 8'hF0, 8'h20, 0);
  endtask

  task automatic t_fn_high;
    for (int c = 8; c < 16; c++)
      for (int p = 0; p < 6; p++) begin
        int x = pats[p];
        int y = pats[(p + 3) % 6];
        int r = ref16(c, x, y);
        apply(0, c, 0, 0, 0, 0, 0, x, y);
        chk("R2 fn high", r, y, r == 0);
      end
  endtask

  task automatic t_imm;
    for (int op = 0; op < 4; op++)
      for (int p = 0; p < 6; p++) begin
        int k = (p * 37 + 11) % 128;
        int r = refimm(op, pats[p], k);
        // upper code bits set to a nonzero value: must not matter
        apply(1, op + 4 * ((p % 3) + 1), 0, 0, k, 0, 0, pats[p], 8'h99);
        chk("R3 imm op", r, 8'h99, r == 0);
      end
    apply(1, 0, 0, 0, 7'h7F, 0, 0, 8'hF0, 0);
    chk("R3 add wraps", 8'h6F, 0, 0);
  endtask

  task automatic t_dest;
    apply(1, 0, 1, 0, 3, 0, 0, 8'h44, 8'h10);
    chk("R4 imm to B", 8'h44, 8'h13, 0);
    apply(1, 3, 0, 0, 7'h01, 0, 0, 8'h40, 8'h10);
    chk("R4 imm to A", 8'h41, 8'h10, 0);
    apply(3, 0, 1, 1, 0, 2, 1, 8'h77, 8'h05);
    chk("R4 shadd to B", 8'h77, 8'h15, 0);
    apply(3, 0, 0, 0, 0, 1, 0, 8'h08, 8'h66);
    chk("R4 shadd to A", 8'h04, 8'h66, 0);
  endtask

  task automatic t_ext_right;
    for (int i = 0; i < 8; i++)
      for (int p = 1; p < 6; p++) begin
        int f = ref_field(0, i + 1, pats[p]);
        apply(2, 0, 0, 0, 0, i, 0, 8'hC3, pats[p]);
        chk("R5 extract right", f, ref_rest(0, i + 1, pats[p]), f == 0);
      end
    apply(2, 0, 0, 0, 0, 0, 0, 8'hFF, 8'h03);
    chk("R5 one bit right", 8'h01, 8'h01, 0);
  endtask

  task automatic t_ext_left;
    for (int i = 0; i < 8; i++)
      for (int p = 1; p < 6; p++) begin
        int f = ref_field(1, i + 1, pats[p]);
        apply(2, 0, 0, 1, 0, i, 0, 8'h3C, pats[p]);
        chk("R6 extract left", f, ref_rest(1, i + 1, pats[p]), f == 0);
      end
    apply(2, 0, 0, 1, 0, 2, 0, 0, 8'hA0);
    chk("R6 left order", 8'h05, 8'h00, 0);
  endtask

  task automatic t_ext_full;
    apply(2, 0, 0, 0, 0, 7, 0, 8'h11, 8'hB6);
    chk("R7 full right", 8'hB6, 8'h00, 0);
    apply(2, 0, 0, 1, 0, 7, 0, 8'h11, 8'h6B);
    chk("R7 full left", 8'h6B, 8'h00, 0);
    apply(2, 0, 0, 0, 0, 3, 0, 8'hFF, 8'hFF);
    chk("R7 upper bits clear", 8'h0F, 8'h0F, 0);
  endtask

  task automatic t_shadd;
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < 8; i++) begin
        int s = pats[(i % 5) + 1];
        int j = (i * 5 + l * 3) % 16;
        int r = ref_shadd(l, s, i, j);
        apply(3, 0, 0, l, 0, i, j, s, 8'h5A);
        chk("R8 shift add", r, 8'h5A, r == 0);
      end
    apply(3, 0, 0, 1, 0, 1, 15, 8'hF9, 0);
    chk("R8 wrap", 8'h01, 0, 0);
  endtask

  task automatic t_zero;
    apply(0, 2, 0, 0, 0, 0, 0, 8'h5A, 8'h5A);
    chk("R9 sub equal", 0, 8'h5A, 1);
    apply(2, 0, 0, 0, 0, 1, 0, 8'h33, 8'hF0);
    chk("R9 extract empty field", 0, 8'h3C, 1);
    apply(1, 2, 1, 0, 7'h0F, 0, 0, 8'h00, 8'hF0);
    chk("R9 B dest zero, A zero", 0, 0, 1);
    apply(1, 2, 1, 0, 7'h0F, 0, 0, 8'h00, 8'hF1);
    chk("R9 B dest nonzero, A zero", 0, 1, 0);
    apply(3, 0, 0, 0, 0, 7, 0, 8'h7F, 8'h00);
    chk("R9 shadd to zero", 0, 0, 1);
  endtask

  task automatic run_all;
    t_idle;
    t_fn_low;
    t_fn_high;
    t_imm;
    t_dest;
    t_ext_right;
    t_ext_left;
    t_ext_full;
    t_shadd;
    t_zero;
  endtask

  initial begin
    kind = 0; code = 0; dstb = 0; dirl = 0; imm = 0; sh = 0; addn = 0;
    a = 0; b = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    fork
      run_all;
      begin
        repeat (50000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule